// File: doc/BRIEF.md
# Infrared Serial Pulse Decoder

This block turns the pulse stream from an infrared receiver into the plain serial level that a UART receiver expects. On the infrared line, a bit cell that holds a short low pulse carries a 0, and a cell with no pulse carries a 1. The block samples the raw line on the system clock and turns each falling edge into a single-cycle event. Because it samples on the system clock and not on the slower bit clock, it still catches pulses that last only one system clock.

A 4-bit cell counter advances on a baud-rate enable that ticks 16 times per bit. An accepted falling edge puts the counter back to zero, so the block locks onto the phase of the transmitter. The output level is written when the counter moves to 8. As a result, the decoded stream trails the infrared stream by half a bit. Once a pulse has been taken, further edges are ignored until the counter reaches 12. This keeps ringing or a stretched pulse from moving the cell timing. When the enable input is low, the output rests at 1.

Top module: `irda_rx_decoder`

## Requirements
- R1: While `rx_en` is low, or while the block is in reset, `rxd` is 1. The counter is held at 0, the pulse window is open, and falling edges on `ir_rx` have no effect once the block is enabled again.
- R2: After a falling edge of `ir_rx` is accepted, `rxd` becomes 0 on the clock edge that carries the 8th `baud_tick` that follows. After 7 ticks, `rxd` still shows its earlier value.
- R3: In a bit cell with no accepted falling edge (the counter wraps from 15 to 0 without one), `rxd` becomes 1 at count 8 of that cell.
- R4: A falling edge that arrives while the counter is between 0 and 11 after an accepted edge is ignored. It neither restarts the counter nor marks the cell as holding a pulse.
- R5: The pulse window reopens when the counter reaches 12. A falling edge accepted at count 12 or later restarts the counter at 0, and the new cell decodes as 0.
- R6: An `ir_rx` low pulse that lasts a single system clock is detected.
- R7: A stream of 16-tick cells with a pulse at the start of each 0 cell decodes to the matching bit sequence on `rxd`, one value per cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_en | input | 1 | Decoder enable; when low, the output is held at the idle level |
| baud_tick | input | 1 | Baud-rate clock enable, 16 pulses per bit |
| ir_rx | input | 1 | Raw infrared receive line, active-low pulses |
| rxd | output | 1 | Decoded serial level for the UART |

## Verification
A single pulse is followed tick by tick. This shows whether the output changes exactly on the 8th tick or one tick early. It also shows whether a cell without a pulse returns the line to 1. Second pulses are sent after 5, 11 and 12 ticks. These show whether the window opens exactly at count 12 and whether ignored edges are kept out of both the counter and the pulse mark. A mixed bit pattern checks decoding across back-to-back cells. Disabling the block during operation, and resetting it, confirm that the output returns to idle and that edges seen during that time are discarded.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;
  localparam int unsigned DEF_CNT_W = 4;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic accept;  // falling edge taken inside open window
    logic update;  // counter stepping onto the mid-cell point
  } irda_evt_t;
endpackage

// File: rtl/irda_rx_sync.sv
module irda_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
  end

  for (genvar i = 1; i < LEN; i++) begin : g_stage
    always_comb begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign fall = chain_q[LEN-1] & ~chain_q[LEN-2];
endmodule

// File: rtl/irda_rx_timer.sv
module irda_rx_timer
  import irda_rx_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             fall,
  output irda_evt_t        evt,
  output logic [CNT_W-1:0] cnt,
  output logic             win_open
);
  localparam int unsigned CELL   = 1 << CNT_W;
  localparam int unsigned MID    = CELL / 2;
  localparam int unsigned WIN_AT = (CELL * 3) / 4;
  localparam logic [CNT_W-1:0] MID_M1 = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] WIN_V  = CNT_W'(WIN_AT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             win_q, win_d;
  logic             accept;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    accept  = en & fall & win_q;
    cnt_inc = cnt_q + 1'b1;
    cnt_d   = cnt_q;
    win_d   = win_q;
    if (!en) begin
      cnt_d = '0;
      win_d = 1'b1;
    end else if (accept) begin
      cnt_d = '0;
      win_d = 1'b0;
    end else if (tick) begin
      cnt_d = cnt_inc;
      if (cnt_inc == WIN_V) win_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  assign evt.accept = accept;
  assign evt.update = en & tick & ~accept & (cnt_q == MID_M1);
  assign cnt        = cnt_q;
  assign win_open   = win_q;
endmodule

// File: rtl/irda_rx_out.sv
module irda_rx_out
  import irda_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  irda_evt_t evt,
  output logic      rxd,
  output logic      pulse_seen
);
  logic rxd_q, rxd_d;
  logic seen_q, seen_d;

  always_comb begin
    rxd_d  = rxd_q;
    seen_d = seen_q;
    if (!en) begin
      rxd_d  = 1'b1;
      seen_d = 1'b0;
    end else if (evt.accept) begin
      seen_d = 1'b1;
    end else if (evt.update) begin
      rxd_d  = ~seen_q;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q  <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      rxd_q  <= rxd_d;
      seen_q <= seen_d;
    end
  end

  assign rxd        = rxd_q;
  assign pulse_seen = seen_q;
endmodule

// File: rtl/irda_rx_decoder.sv
module irda_rx_decoder
  import irda_rx_pkg::*;
#(
  parameter int unsigned CNT_W     = DEF_CNT_W,
  parameter int unsigned SYNC_STGS = DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic baud_tick,
  input  logic ir_rx,
  output logic rxd
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             ir_fall;
  irda_evt_t        evt;
  logic [CNT_W-1:0] cell_cnt;
  logic             win_open;
  logic             pulse_seen;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  irda_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .din  (ir_rx),
    .fall (ir_fall)
  );

  irda_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (rx_en),
    .tick    (baud_tick),
    .fall    (ir_fall),
    .evt     (evt),
    .cnt     (cell_cnt),
    .win_open(win_open)
  );

  irda_rx_out u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .en        (rx_en),
    .evt       (evt),
    .rxd       (rxd),
    .pulse_seen(pulse_seen)
  );
endmodule

// File: rtl/irda_rx_decoder_chk.sv
module irda_rx_decoder_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rxd,
  input logic             update,
  input logic             accept,
  input logic             win_open,
  input logic [CNT_W-1:0] cnt,
  input logic             pulse_seen
);
  localparam logic [CNT_W-1:0] WIN_V = CNT_W'(((1 << CNT_W) * 3) / 4);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> rxd);

  p_update_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd != $past(rxd)) |-> ($past(update) || !$past(en)));

  p_fall_needs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd) |-> $past(pulse_seen));

  p_rise_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd) |-> (!$past(pulse_seen) || !$past(en)));

  p_accept_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!win_open && cnt == '0));

  p_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> (cnt == WIN_V || !$past(en)));
endmodule

bind irda_rx_decoder irda_rx_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .en        (rx_en),
  .rxd       (rxd),
  .update    (evt.update),
  .accept    (evt.accept),
  .win_open  (win_open),
  .cnt       (cell_cnt),
  .pulse_seen(pulse_seen)
);

// File: tb/tb_irda_rx_decoder.sv
`timescale 1ns/1ps
module tb_irda_rx_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic baud_tick = 1'b0;
  logic ir_rx = 1'b1;
  logic rxd;
  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  irda_rx_decoder dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .baud_tick(baud_tick), .ir_rx(ir_rx), .rxd(rxd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rxd=%b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_en = 1'b1; baud_tick = 1'b0; ir_rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // single system-clock-wide low pulse (R6), then let the edge be taken
  task automatic pulse();
    ir_rx = 1'b0;
    @(negedge clk);
    ir_rx = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset idle", rxd, 1'b1);
    ticks(10);
    chk("R3 no pulse after reset", rxd, 1'b1);
  endtask

  task automatic t_lag();
    do_reset();
    pulse();
    ticks(7);
    chk("R2 unchanged after 7 ticks", rxd, 1'b1);
    ticks(1);
    chk("R2 low at 8th tick", rxd, 1'b0);
    chk("R6 one-clock pulse seen", rxd, 1'b0);
    ticks(15);
    chk("R3 held until next mid-cell", rxd, 1'b0);
    ticks(1);
    chk("R3 empty cell gives 1", rxd, 1'b1);
  endtask

  task automatic t_closed();
    do_reset();
    pulse();
    ticks(5);
    pulse();
    ticks(3);
    chk("R4 early edge no resync", rxd, 1'b0);
    ticks(16);
    chk("R4 early edge not marked", rxd, 1'b1);
  endtask

  task automatic t_eleven();
    do_reset();
    pulse();
    ticks(11);
    pulse();
    ticks(8);
    chk("R4 edge at 11 keeps level", rxd, 1'b0);
    ticks(5);
    chk("R4 edge at 11 ignored", rxd, 1'b1);
  endtask

  task automatic t_twelve();
    do_reset();
    pulse();
    ticks(12);
    pulse();
    ticks(8);
    chk("R5 edge at 12 cell low", rxd, 1'b0);
    ticks(4);
    chk("R5 edge at 12 resyncs", rxd, 1'b0);
    ticks(12);
    chk("R5 following empty cell", rxd, 1'b1);
  endtask

  task automatic t_pattern();
    logic [7:0] bits = 8'b1010_0110;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      if (!bits[i]) pulse();
      ticks(8);
      chk($sformatf("R7 cell %0d", i), rxd, bits[i]);
      ticks(8);
    end
  endtask

  task automatic t_disable();
    do_reset();
    pulse();
    ticks(8);
    chk("R2 low before disable", rxd, 1'b0);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R1 disable forces idle", rxd, 1'b1);
    pulse();
    ticks(8);
    chk("R1 pulse while disabled", rxd, 1'b1);
    rx_en = 1'b1;
    @(negedge clk);
    ticks(8);
    chk("R1 no pulse kept", rxd, 1'b1);
    pulse();
    ticks(8);
    chk("R1 decodes after enable", rxd, 1'b0);
  endtask

  task automatic t_async_reset();
    do_reset();
    pulse();
    ticks(8);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset forces idle", rxd, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_lag();
    t_closed();
    t_eleven();
    t_twelve();
    t_pattern();
    t_disable();
    t_async_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: rxd=%b expected finish", rxd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule